// File: doc/BRIEF.md
# Vertical strip scan sequencer

This block produces read addresses into an image line buffer so that pixels leave in vertical strips rather than in raster order. A strip is a fixed number of rows tall (16 by default, equal to one coding block). The scan goes down one column from the top row to the bottom row of the strip, then moves to the top row of the next column, until every column of the image width has been visited. One address is issued per clock cycle with no gaps for the whole strip.

Along with each address, the sequencer raises framing flags that later coding stages use to bound their state. A block-end flag marks the bottom sample of each column. A segment-start flag marks the first sample of every S-th block. A reference-sample flag marks the first sample of every R-th block, and a reference-block flag stays high on all samples of such a block. Block, segment and interval counts restart at every strip, so no coding state crosses from one strip into the next. The interval length R can be changed at run time. A new value is held as pending and takes effect only at the next interval boundary or the next strip start. A single-cycle done pulse follows the last sample, and the sequencer then waits for the next start.

Top module: `vstrip_scan_seq`

## Requirements
- R1: For a strip accepted with base B and width W, the k-th valid sample (counting from 0) has row r = k mod 16 and column c = k div 16, and `rd_addr` = (B + r*W + c) mod 2^ADDR_W.
- R2: A start accepted at a clock edge gives the first valid sample right after the next edge. `rd_valid` then stays high for exactly 16*W consecutive cycles.
- R3: `blk_end` is high on the sample with r = 15 (the 16th sample of each column block) and low on every other sample.
- R4: `seg_start` is high on the first sample (r = 0) of blocks 0, S, 2S, … counted from the strip start (S = 64 by default) and low elsewhere.
- R5: `ref_sample` is high on the first sample of blocks 0, R, 2R, … of the current interval sequence. `ref_block` is high on all 16 samples of those blocks and low on all other samples.
- R6: After reset all outputs are low and the interval length R is 32.
- R7: A pulse on `ref_load` with a nonzero `ref_value` sets a pending R. The pending R becomes the active R at the end of the current interval, or at the next strip start, whichever comes first. A load with value 0 is ignored.
- R8: `scan_done` is high for exactly one cycle, in the cycle after the last valid sample. After it, `rd_valid` stays low until a new start is accepted.
- R9: `start` is ignored while a strip is in progress, and it is ignored when `img_width` is 0.
- R10: All framing flags are low in every cycle in which `rd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a strip scan (sampled when idle) |
| strip_base | input | ADDR_W | Buffer address of the strip's top-left pixel, latched at start |
| img_width | input | COL_W | Number of columns (line stride), latched at start |
| ref_load | input | 1 | Load strobe for a new interval length |
| ref_value | input | REF_W | Interval length in blocks (0 ignored) |
| rd_addr | output | ADDR_W | Buffer read address |
| rd_valid | output | 1 | `rd_addr` and flags are valid |
| ref_sample | output | 1 | Reference sample: first sample of an interval's first block |
| seg_start | output | 1 | First sample of a segment |
| ref_block | output | 1 | Sample belongs to the first block of an interval |
| blk_end | output | 1 | Last sample of a block |
| scan_done | output | 1 | One-cycle pulse after the last sample |

## Verification
The scan is run with widths of 1, 3, 5, 20, 40 and 70 columns, with one base placed so that addresses wrap. This separates row-stride errors from column-step errors and exposes end-of-strip off-by-one faults. Interval lengths of 32, 2, 3 and 5 are used, with loads both while idle and mid-strip. This shows whether a new length waits for the boundary, whether a zero load is dropped, and whether flag positions follow the block count rather than the column count. A 70-column strip puts a second segment start at block 64. Starts issued mid-strip and with zero width check that the running scan is left intact.

// File: rtl/vstrip_pkg.sv
package vstrip_pkg;
  typedef struct packed {
    logic ref_smp;
    logic seg_first;
    logic ref_blk;
    logic blk_last;
  } scan_flags_t;
endpackage

// File: rtl/vstrip_walker.sv
module vstrip_walker #(
  parameter int ADDR_W = 16,
  parameter int COL_W  = 12,
  parameter int ROWS   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_in,
  input  logic [COL_W-1:0]  width_in,
  output logic              busy,
  output logic              accept,
  output logic              row_first,
  output logic              row_last,
  output logic              col_last,
  output logic [COL_W-1:0]  col,
  output logic [ADDR_W-1:0] row_off,
  output logic [ADDR_W-1:0] base_q
);
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1;

  logic [ROW_W-1:0] row;
  logic [COL_W-1:0] width_q;

  assign accept    = start && !busy && (width_in != '0);
  assign row_first = (row == '0);
  assign row_last  = (row == ROW_W'(ROWS - 1));
  assign col_last  = (col == width_q - COL_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      row     <= '0;
      col     <= '0;
      row_off <= '0;
      width_q <= '0;
      base_q  <= '0;
    end else if (accept) begin
      busy    <= 1'b1;
      row     <= '0;
      col     <= '0;
      row_off <= '0;
      width_q <= width_in;
      base_q  <= base_in;
    end else if (busy) begin
      if (row_last) begin
        row     <= '0;
        row_off <= '0;
        if (col_last) begin
          busy <= 1'b0;
        end else begin
          col <= col + COL_W'(1);
        end
      end else begin
        row     <= row + ROW_W'(1);
        row_off <= row_off + ADDR_W'(width_q);
      end
    end
  end
endmodule

// File: rtl/vstrip_framer.sv
module vstrip_framer #(
  parameter int SEG_BLOCKS  = 64,
  parameter int REF_W       = 8,
  parameter int REF_DEFAULT = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scan_begin,
  input  logic             blk_advance,
  input  logic             ref_load,
  input  logic [REF_W-1:0] ref_value,
  output logic             seg_first,
  output logic             int_first
);
  localparam int  SEG_W   = (SEG_BLOCKS > 1) ? $clog2(SEG_BLOCKS) : 1;
  localparam bit  SEG_POW2 = ((SEG_BLOCKS & (SEG_BLOCKS - 1)) == 0);

  logic [SEG_W-1:0] seg_cnt;
  logic [REF_W-1:0] ref_cnt;
  logic [REF_W-1:0] ref_active;
  logic [REF_W-1:0] ref_pending;
  logic             int_last;

  assign seg_first = (seg_cnt == '0);
  assign int_first = (ref_cnt == '0);
  assign int_last  = (ref_cnt == ref_active - REF_W'(1));

  generate
    if (SEG_POW2) begin : g_seg_wrap
      always_ff @(posedge clk) begin
        if (rst || scan_begin) seg_cnt <= '0;
        else if (blk_advance)  seg_cnt <= seg_cnt + SEG_W'(1);
      end
    end else begin : g_seg_cmp
      always_ff @(posedge clk) begin
        if (rst || scan_begin) seg_cnt <= '0;
        else if (blk_advance)
          seg_cnt <= (seg_cnt == SEG_W'(SEG_BLOCKS - 1)) ? '0 : seg_cnt + SEG_W'(1);
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_cnt    <= '0;
      ref_active <= REF_W'(REF_DEFAULT);
    end else if (scan_begin) begin
      ref_cnt    <= '0;
      ref_active <= ref_pending;
    end else if (blk_advance) begin
      if (int_last) begin
        ref_cnt    <= '0;
        ref_active <= ref_pending;
      end else begin
        ref_cnt <= ref_cnt + REF_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ref_pending <= REF_W'(REF_DEFAULT);
    else if (ref_load && (ref_value != '0)) ref_pending <= ref_value;
  end
endmodule

// File: rtl/vstrip_scan_seq.sv
module vstrip_scan_seq
  import vstrip_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int COL_W       = 12,
  parameter int STRIP_ROWS  = 16,
  parameter int SEG_BLOCKS  = 64,
  parameter int REF_W       = 8,
  parameter int REF_DEFAULT = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] strip_base,
  input  logic [COL_W-1:0]  img_width,
  input  logic              ref_load,
  input  logic [REF_W-1:0]  ref_value,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic              ref_sample,
  output logic              seg_start,
  output logic              ref_block,
  output logic              blk_end,
  output logic              scan_done
);
  logic              busy, accept, row_first, row_last, col_last;
  logic [COL_W-1:0]  col;
  logic [ADDR_W-1:0] row_off, base_q;
  logic              seg_first, int_first;
  logic              last_q;
  scan_flags_t       flags_d, flags_q;

  vstrip_walker #(.ADDR_W(ADDR_W), .COL_W(COL_W), .ROWS(STRIP_ROWS)) u_walker (
    .clk(clk), .rst(rst), .start(start), .base_in(strip_base), .width_in(img_width),
    .busy(busy), .accept(accept), .row_first(row_first), .row_last(row_last),
    .col_last(col_last), .col(col), .row_off(row_off), .base_q(base_q)
  );

  vstrip_framer #(.SEG_BLOCKS(SEG_BLOCKS), .REF_W(REF_W), .REF_DEFAULT(REF_DEFAULT)) u_framer (
    .clk(clk), .rst(rst), .scan_begin(accept), .blk_advance(busy && row_last),
    .ref_load(ref_load), .ref_value(ref_value),
    .seg_first(seg_first), .int_first(int_first)
  );

  always_comb begin
    flags_d           = '0;
    flags_d.ref_smp   = busy && row_first && int_first;
    flags_d.seg_first = busy && row_first && seg_first;
    flags_d.ref_blk   = busy && int_first;
    flags_d.blk_last  = busy && row_last;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_addr   <= '0;
      rd_valid  <= 1'b0;
      flags_q   <= '0;
      last_q    <= 1'b0;
      scan_done <= 1'b0;
    end else begin
      rd_addr   <= base_q + row_off + ADDR_W'(col);
      rd_valid  <= busy;
      flags_q   <= flags_d;
      last_q    <= busy && row_last && col_last;
      scan_done <= last_q;
    end
  end

  assign ref_sample = flags_q.ref_smp;
  assign seg_start  = flags_q.seg_first;
  assign ref_block  = flags_q.ref_blk;
  assign blk_end    = flags_q.blk_last;
endmodule

// File: rtl/vstrip_checker.sv
module vstrip_checker (
  input logic clk,
  input logic rst,
  input logic rd_valid,
  input logic ref_sample,
  input logic seg_start,
  input logic ref_block,
  input logic blk_end,
  input logic scan_done
);
  a_r10_flags_need_valid: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |-> !(ref_sample || seg_start || ref_block || blk_end));

  a_r5_ref_inside_ref_block: assert property (@(posedge clk) disable iff (rst)
    ref_sample |-> ref_block);

  a_r5_ref_block_steady: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !blk_end) |=> $stable(ref_block));

  a_r2_no_gap_in_column: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !blk_end) |=> rd_valid);

  a_r5_ref_at_block_start: assert property (@(posedge clk) disable iff (rst)
    ref_sample |-> (!$past(rd_valid) || $past(blk_end)));

  a_r4_seg_at_block_start: assert property (@(posedge clk) disable iff (rst)
    seg_start |-> (!$past(rd_valid) || $past(blk_end)));

  a_r8_done_after_block_end: assert property (@(posedge clk) disable iff (rst)
    scan_done |-> ($past(rd_valid) && $past(blk_end) && !rd_valid));

  a_r8_done_single_cycle: assert property (@(posedge clk) disable iff (rst)
    scan_done |=> !scan_done);
endmodule

bind vstrip_scan_seq vstrip_checker u_vstrip_checker (
  .clk(clk), .rst(rst), .rd_valid(rd_valid), .ref_sample(ref_sample),
  .seg_start(seg_start), .ref_block(ref_block), .blk_end(blk_end),
  .scan_done(scan_done)
);

// File: tb/test_vstrip_scan_seq.sv
module test_vstrip_scan_seq;
  localparam int ADDR_W = 16;
  localparam int COL_W  = 12;
  localparam int REF_W  = 8;
  localparam int ROWS   = 16;
  localparam int SEGS   = 64;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [ADDR_W-1:0] strip_base = '0;
  logic [COL_W-1:0]  img_width = '0;
  logic              ref_load = 1'b0;
  logic [REF_W-1:0]  ref_value = '0;
  logic [ADDR_W-1:0] rd_addr;
  logic              rd_valid, ref_sample, seg_start, ref_block, blk_end, scan_done;

  vstrip_scan_seq i_vstrip_scan_seq (
    .clk(clk), .rst(rst), .start(start), .strip_base(strip_base), .img_width(img_width),
    .ref_load(ref_load), .ref_value(ref_value), .rd_addr(rd_addr), .rd_valid(rd_valid),
    .ref_sample(ref_sample), .seg_start(seg_start), .ref_block(ref_block),
    .blk_end(blk_end), .scan_done(scan_done)
  );

  always #4 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", what, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_busy, m_row, m_col, m_w, m_base, m_segc, m_refc, m_act, m_pend;
  int e_valid, e_addr, e_ref, e_seg, e_rblk, e_end, e_done, e_last;

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_row = 0; m_col = 0; m_w = 0; m_base = 0; m_segc = 0; m_refc = 0;
      m_act = 32; m_pend = 32;
      e_valid = 0; e_addr = 0; e_ref = 0; e_seg = 0; e_rblk = 0; e_end = 0; e_done = 0; e_last = 0;
    end else begin
      int old_pend;
      e_done  = e_last;
      e_valid = m_busy;
      e_addr  = (m_base + m_row * m_w + m_col) % (1 << ADDR_W);
      e_ref   = m_busy && m_row == 0 && m_refc == 0;
      e_seg   = m_busy && m_row == 0 && m_segc == 0;
      e_rblk  = m_busy && m_refc == 0;
      e_end   = m_busy && m_row == ROWS - 1;
      e_last  = m_busy && m_row == ROWS - 1 && m_col == m_w - 1;
      old_pend = m_pend;
      if (!m_busy && start && img_width != 0) begin
        m_busy = 1; m_row = 0; m_col = 0; m_w = int'(img_width); m_base = int'(strip_base);
        m_segc = 0; m_refc = 0; m_act = old_pend;
      end else if (m_busy) begin
        if (m_row == ROWS - 1) begin
          m_row = 0;
          m_segc = (m_segc + 1) % SEGS;
          if (m_refc == m_act - 1) begin m_refc = 0; m_act = old_pend; end
          else m_refc++;
          if (m_col == m_w - 1) m_busy = 0; else m_col++;
        end else m_row++;
      end
      if (ref_load && ref_value != 0) m_pend = int'(ref_value);
    end
  end

  int cnt_valid = 0, cnt_ref = 0, cnt_seg = 0, cnt_done = 0;

  always @(negedge clk) begin
    if (!rst) begin
      check(rd_valid == e_valid[0], "R2 rd_valid", rd_valid, e_valid);
      if (e_valid != 0) check(int'(rd_addr) == e_addr, "R1 rd_addr", rd_addr, e_addr);
      check(blk_end == e_end[0], "R3 blk_end", blk_end, e_end);
      check(seg_start == e_seg[0], "R4 seg_start", seg_start, e_seg);
      check(ref_sample == e_ref[0], "R5 ref_sample", ref_sample, e_ref);
      check(ref_block == e_rblk[0], "R5 ref_block / R10 idle flags", ref_block, e_rblk);
      check(scan_done == e_done[0], "R8 scan_done", scan_done, e_done);
      if (rd_valid) cnt_valid++;
      if (ref_sample) cnt_ref++;
      if (seg_start) cnt_seg++;
      if (scan_done) cnt_done++;
    end
  end

  task automatic clear_counts();
    cnt_valid = 0; cnt_ref = 0; cnt_seg = 0; cnt_done = 0;
  endtask

  task automatic pulse_start(input int base, input int width);
    @(negedge clk);
    clear_counts();
    strip_base = ADDR_W'(base);
    img_width  = COL_W'(width);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    int guard = 0;
    while (cnt_done == 0 && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic load_ref(input int v);
    @(negedge clk);
    ref_load = 1'b1;
    ref_value = REF_W'(v);
    @(negedge clk);
    ref_load = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R6: reset state
    check(rd_valid == 1'b0 && scan_done == 1'b0, "R6 reset valid/done", rd_valid, 0);
    check({ref_sample, seg_start, ref_block, blk_end} == 4'b0, "R6 reset flags",
          {ref_sample, seg_start, ref_block, blk_end}, 0);
    @(negedge clk);
    rst = 1'b0;

    // short strip, default interval
    pulse_start(100, 3);
    wait_done();
    check(cnt_valid == 48, "R2 sample count w3", cnt_valid, 48);
    check(cnt_ref == 1 && cnt_seg == 1, "R5 flags w3", cnt_ref, 1);
    check(cnt_done == 1, "R8 done count w3", cnt_done, 1);

    // R6 default R=32, address wrap
    pulse_start(65500, 40);
    wait_done();
    check(cnt_ref == 2, "R6 default interval refs", cnt_ref, 2);
    check(cnt_valid == 640, "R2 sample count w40", cnt_valid, 640);

    // R7 load while idle applies at next start
    load_ref(2);
    pulse_start(7, 5);
    wait_done();
    check(cnt_ref == 3, "R7 idle load R=2", cnt_ref, 3);

    // R7 mid-strip load waits for boundary, zero load ignored
    load_ref(3);
    pulse_start(0, 20);
    repeat (4 * 16 + 3) @(negedge clk);
    ref_load = 1'b1; ref_value = 8'd5;
    @(negedge clk);
    ref_load = 1'b0;
    repeat (8 * 16 - 1) @(negedge clk);
    ref_load = 1'b1; ref_value = 8'd0;
    @(negedge clk);
    ref_load = 1'b0;
    wait_done();
    check(cnt_ref == 5, "R7 boundary switch and zero load", cnt_ref, 5);

    // R4 second segment at block 64
    pulse_start(300, 70);
    wait_done();
    check(cnt_seg == 2, "R4 segment starts w70", cnt_seg, 2);
    check(cnt_ref == 14, "R5 refs w70 R=5", cnt_ref, 14);

    // R9 start while busy ignored
    pulse_start(50, 2);
    repeat (8) @(negedge clk);
    strip_base = 16'd999; img_width = 12'd9; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    check(cnt_valid == 32, "R9 start ignored while busy", cnt_valid, 32);

    // R9 zero width ignored
    pulse_start(10, 0);
    repeat (20) @(negedge clk);
    check(cnt_valid == 0 && cnt_done == 0, "R9 zero width ignored", cnt_valid, 0);

    // single column
    pulse_start(1234, 1);
    wait_done();
    check(cnt_valid == 16 && cnt_done == 1, "R8 single column", cnt_valid, 16);

    finish_run();
  end
endmodule